// File: doc/BRIEF.md
# Transmit Packet FIFO with Watermarks

This block is a single-clock, byte-wide queue that sits between a user write port and a MAC transmit engine. Each stored byte carries an end-of-packet marker. The queue counts how many complete packets it holds.

On the write side it drives a write-available flag. That flag drops once the fill level reaches a high watermark. On the read side it drives a registered read-available flag, which rises when a whole packet is stored or when the fill level has reached a low watermark. Because that flag is registered, it lags by one cycle. For this reason the block also gives an immediate empty flag, so the engine does not start a new frame when no data is present.

The read port is show-ahead: the byte at the head and its marker are visible before they are popped. A consumer that pops while the queue is empty sends the read-side tracker into a sticky error state. Only reset clears that state.

Top module: `tx_pkt_fifo`

## Requirements
- R1: After synchronous reset, `empty` is 1, `fill` and `pkt_cnt` are 0, `rd_avail` is 0, `rd_err` is 0 and `wr_avail` is 1.
- R2: Bytes and their end-of-packet bits leave in the order they were accepted. `rd_data`/`rd_eop` show the head entry whenever `empty` is 0.
- R3: `wr_avail` is 1 exactly when `fill` is below HIGH_MARK. It follows `fill` in the same cycle.
- R4: `rd_avail` is a register. After each clock edge it equals (`pkt_cnt` was nonzero) OR (`fill` was at least LOW_MARK), both taken before that edge.
- R5: An accepted write with `wr_eop`=1 adds one to `pkt_cnt`. An accepted pop whose head has `rd_eop`=1 subtracts one. Both take effect at the next edge.
- R6: `empty` is combinational and is 1 exactly when `fill` is 0.
- R7: `rd_en`=1 while `empty`=1 sets `rd_err` from the next edge on. The flag then stays 1 until reset.
- R8: A write while `fill` equals DEPTH is dropped. `fill` and the stored contents are unchanged.
- R9: A pop while empty removes nothing. A byte written later is read back intact.
- R10: If, in the same cycle, an end-of-packet byte is written and an end-of-packet byte is popped, `pkt_cnt` stays the same.
- R11: When the only stored packet is drained below LOW_MARK, `rd_avail` is still 1 in the first cycle where `empty` is 1. It is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Byte to store |
| wr_eop | input | 1 | Byte ends a packet |
| wr_avail | output | 1 | Fill is below high watermark |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head byte (show-ahead) |
| rd_eop | output | 1 | Head byte ends a packet |
| rd_avail | output | 1 | Registered read-available flag |
| empty | output | 1 | Nothing stored (combinational) |
| rd_err | output | 1 | Sticky read-while-empty error |
| fill | output | CW | Stored entries |
| pkt_cnt | output | CW | Complete packets stored |

## Verification
`empty`, `wr_avail` and the head byte change in the cycle right after the edge that accepts a write or pop. `fill` and `pkt_cnt` change at that same edge. `rd_avail` is one edge later: it reflects the state from before the edge that loads it. `rd_err` rises at the edge after the bad pop. The bench updates its reference model at each rising edge, keeping the read-available term one step behind. It compares every output at the falling edge, before it drives the next stimulus, so each result is sampled in the cycle it is due.

// File: rtl/tx_pkt_fifo.sv
module tx_pkt_fifo #(
  parameter int DEPTH     = 256,
  parameter int HIGH_MARK = 224,
  parameter int LOW_MARK  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          wr_eop,
  output logic          wr_avail,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          rd_eop,
  output logic          rd_avail,
  output logic          empty,
  output logic          rd_err,
  output logic [CW-1:0] fill,
  output logic [CW-1:0] pkt_cnt
);

  typedef enum logic {RD_OK, RD_FAULT} rd_state_t;

  logic [8:0]  mem [DEPTH];
  logic [AW:0] wp, rp;
  rd_state_t   rd_st;

  assign fill     = wp - rp;
  assign empty    = (wp == rp);
  assign wr_avail = fill < CW'(HIGH_MARK);
  assign rd_err   = (rd_st == RD_FAULT);
  assign {rd_eop, rd_data} = mem[rp[AW-1:0]];

  wire full   = (fill == CW'(DEPTH));
  wire wr_go  = wr_en && !full;
  wire rd_go  = rd_en && !empty;
  wire cnt_up = wr_go && wr_eop;
  wire cnt_dn = rd_go && rd_eop;

  always_ff @(posedge clk)
    if (wr_go) mem[wp[AW-1:0]] <= {wr_eop, wr_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      pkt_cnt  <= '0;
      rd_avail <= 1'b0;
      rd_st    <= RD_OK;
    end else begin
      if (wr_go) wp <= wp + 1'b1;
      if (rd_go) rp <= rp + 1'b1;
      if (cnt_up && !cnt_dn)      pkt_cnt <= pkt_cnt + 1'b1;
      else if (cnt_dn && !cnt_up) pkt_cnt <= pkt_cnt - 1'b1;
      rd_avail <= (pkt_cnt != '0) || (fill >= CW'(LOW_MARK));
      if (rd_st == RD_OK && rd_en && empty) rd_st <= RD_FAULT;
    end
  end

endmodule

// File: rtl/tx_pkt_fifo_chk.sv
module tx_pkt_fifo_chk #(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          wr_eop,
  input logic          rd_en,
  input logic          rd_eop,
  input logic          empty,
  input logic          rd_avail,
  input logic          rd_err,
  input logic [CW-1:0] fill,
  input logic [CW-1:0] pkt_cnt
);

  p_err_set_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> rd_err);

  p_err_hold_r7: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> rd_err);

  p_avail_pkt_r4: assert property (@(posedge clk) disable iff (rst)
    (pkt_cnt != '0) |=> rd_avail);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (fill == CW'(DEPTH) && wr_en && !rd_en) |=> (fill == CW'(DEPTH)));

  p_empty_stays_r9: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_en) |=> empty);

  p_cnt_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty && rd_eop && !(wr_en && wr_eop)) |=> (pkt_cnt == $past(pkt_cnt) - 1'b1));

  p_cnt_same_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty && rd_eop && wr_en && wr_eop && fill != CW'(DEPTH)) |=> $stable(pkt_cnt));

endmodule

bind tx_pkt_fifo tx_pkt_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_eop(wr_eop), .rd_en(rd_en),
  .rd_eop(rd_eop), .empty(empty), .rd_avail(rd_avail), .rd_err(rd_err),
  .fill(fill), .pkt_cnt(pkt_cnt)
);

// File: tb/tx_pkt_fifo_test.sv
module tx_pkt_fifo_test;
  localparam int D = 16, HI = 12, LO = 6, CW = 5;

  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_eop = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic wr_avail, rd_eop, rd_avail, empty, rd_err;
  logic [7:0] rd_data;
  logic [CW-1:0] fill, pkt_cnt;

  int errors = 0, checks = 0;
  logic [7:0] qd[$];
  logic       qe[$];
  int  m_cnt = 0;
  bit  m_ravail = 0, m_err = 0;

  always #10 clk = ~clk;

  tx_pkt_fifo #(.DEPTH(D), .HIGH_MARK(HI), .LOW_MARK(LO)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
    .wr_avail(wr_avail), .rd_en(rd_en), .rd_data(rd_data), .rd_eop(rd_eop),
    .rd_avail(rd_avail), .empty(empty), .rd_err(rd_err), .fill(fill),
    .pkt_cnt(pkt_cnt));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic bit exp_wavail(int n); return n < HI; endfunction
  function automatic bit exp_ravail(int c, int n); return (c != 0) || (n >= LO); endfunction

  task automatic check_all();
    chk("R6 empty", empty, qd.size() == 0);
    chk("R8 fill", fill, qd.size());
    chk("R3 wr_avail", wr_avail, exp_wavail(qd.size()));
    chk("R4 rd_avail", rd_avail, m_ravail);
    chk("R5 pkt_cnt", pkt_cnt, m_cnt);
    chk("R7 rd_err", rd_err, m_err);
    if (qd.size() > 0) begin
      chk("R2 rd_data", rd_data, qd[0]);
      chk("R2 rd_eop", rd_eop, qe[0]);
    end
  endtask

  task automatic cyc(input bit we, input logic [7:0] d, input bit e, input bit re);
    bit wgo, rgo, nra;
    check_all();
    wr_en = we; wr_data = d; wr_eop = e; rd_en = re;
    @(posedge clk);
    nra = exp_ravail(m_cnt, qd.size());
    wgo = we && qd.size() < D;
    rgo = re && qd.size() > 0;
    if (re && qd.size() == 0) m_err = 1;
    if (rgo) begin
      if (qe[0]) m_cnt--;
      void'(qd.pop_front()); void'(qe.pop_front());
    end
    if (wgo) begin
      qd.push_back(d); qe.push_back(e);
      if (e) m_cnt++;
    end
    m_ravail = nra;
    @(negedge clk);
    wr_en = 0; rd_en = 0; wr_eop = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    qd.delete(); qe.delete();
    m_cnt = 0; m_ravail = 0; m_err = 0;
  endtask

  task automatic rand_phase(input int n, input int wp, input int rp);
    for (int i = 0; i < n; i++) begin
      bit we, re;
      we = ($urandom % 100) < wp;
      re = (($urandom % 100) < rp) && qd.size() > 0;
      cyc(we, 8'($urandom), ($urandom % 4) == 0, re);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed1));
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 empty", empty, 1);
    chk("R1 fill", fill, 0);
    chk("R1 pkt_cnt", pkt_cnt, 0);
    chk("R1 rd_avail", rd_avail, 0);
    chk("R1 rd_err", rd_err, 0);
    chk("R1 wr_avail", wr_avail, 1);

    // R11 last packet drained: rd_avail lingers one cycle
    cyc(1, 8'hA1, 0, 0);
    cyc(1, 8'hA2, 1, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    chk("R11 empty", empty, 1);
    chk("R11 rd_avail lingers", rd_avail, 1);
    cyc(0, 0, 0, 0);
    chk("R11 rd_avail drops", rd_avail, 0);

    // R10 eop write and eop pop together
    cyc(1, 8'h11, 1, 0);
    cyc(1, 8'h22, 1, 1);
    chk("R10 pkt_cnt same", pkt_cnt, 1);
    cyc(0, 0, 0, 1);

    // R8 overflow attempts
    for (int i = 0; i < D + 4; i++) cyc(1, 8'(i + 8'h40), (i % 5) == 4, 0);
    chk("R8 full fill", fill, D);
    chk("R3 wr_avail low at full", wr_avail, 0);
    for (int i = 0; i < D; i++) cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);

    // random mixes
    rand_phase(3000, 80, 30);
    rand_phase(3000, 30, 80);
    rand_phase(3000, 55, 55);
    while (qd.size() > 0) cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);

    // R7 / R9 pop while empty
    cyc(0, 0, 0, 1);
    chk("R7 rd_err set", rd_err, 1);
    cyc(1, 8'h5A, 1, 0);
    cyc(0, 0, 0, 0);
    chk("R9 data intact", rd_data, 8'h5A);
    chk("R9 fill", fill, 1);
    chk("R7 rd_err held", rd_err, 1);
    cyc(0, 0, 0, 1);
    do_reset();
    chk("R1 rd_err cleared", rd_err, 0);
    check_all();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule